// File: doc/BRIEF.md
# 1-Wire Reset and Slot Timing Engine

This block produces the bus waveforms for a single open-drain 1-Wire line. It handles three operations: a short-pulse bit slot (read or write-1), a long-pulse write-0 slot, and a bus reset with presence detection. Timing counts a 1 µs tick enable, so the system clock can run at any rate that is fast enough. A start strobe latches the operation type and the speed mode. When the operation is finished the block raises `done` for one cycle. It then holds the sampled line level on `result`, together with a flag that reports a stuck-low line.

During a reset the engine checks the line just after it releases the reset pulse. If the line is still low, a device may be signalling an alarm or the line may be shorted. The engine then waits a long timeout for the line to rise. If the line rises in time, presence monitoring and recovery timing start again from that rising edge. If it does not rise, the engine reports a short. Overdrive mode selects a separate, much shorter set of durations.

All durations are parameters. The line input passes through a synchronizer chain whose length is also a parameter.

Top module: `owire_slot_engine`

## Requirements
- R1: Operation codes on `slot_kind`: 2'b00 is a read/write-1 slot, 2'b01 is a write-0 slot and 2'b10 is a bus reset. Out of reset, `drive_low`, `done` and `short_flag` are 0 and `result` is 1.
- R2: A write-0 slot in normal mode holds `drive_low` high for at least 60 µs and no more than 62 µs. Its `done` comes at least 60 µs after start. `result` reads 0.
- R3: A read/write-1 slot in normal mode pulls the line low for 1 to 2 µs. `result` is the line level sampled 15 µs after start, so a device holding the line low past that point gives 0, and a device pulling only after it gives 1.
- R4: `done` is a single-cycle pulse. The line is released when `done` is high. `result` and `short_flag` hold their values until the next start.
- R5: A reset in normal mode drives the line low for at least 480 µs and no more than 482 µs.
- R6: When the line is not held low after release, a normal-mode reset signals `done` between 960 µs and 965 µs after start.
- R7: After a reset, a presence pulse that begins 15 to 60 µs after release gives `result` = 0. No presence pulse gives `result` = 1.
- R8: If the line is still low just after the reset pulse is released, the engine waits up to 3840 µs for it to rise. When the line rises, presence monitoring restarts from that edge, and `done` comes 480 µs after the rise with `short_flag` = 0.
- R9: If the line stays low for the full 3840 µs wait, `done` is raised with `short_flag` = 1 and `result` = 1, about 4324 µs after start.
- R10: With `overdrive` = 1 at start, a reset holds the line low for 70 µs, and a reset's `done` comes about 140 µs after start. A slot samples the line at 2 µs and ends after 8 µs. A write-0 slot holds the line low for 8 µs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle enable, once per microsecond |
| start | input | 1 | Begin an operation (accepted only when idle) |
| slot_kind | input | 2 | Operation code, latched at start |
| overdrive | input | 1 | 1 selects the short timing set, latched at start |
| line_in | input | 1 | Raw level of the 1-Wire line |
| drive_low | output | 1 | 1 pulls the line low |
| done | output | 1 | One-cycle pulse when the operation ends |
| result | output | 1 | Sampled bit, or 0 when a presence pulse was seen |
| short_flag | output | 1 | Line stayed low through the alarm timeout |

## Verification
Read slots are run with three device patterns:
- a device that never pulls the line;
- a device that holds the line low beyond the 15 µs sample point;
- a device that pulls the line only after the sample point.

Together these pin the sample instant to one side of each edge.

Resets are run with four line patterns:
- a presence pulse;
- no response;
- a line held low for 1000 µs and then released, followed by a presence pulse;
- a line that never rises.

These patterns separate the ordinary recovery path, the alarm path that restarts timing at the rising edge, and the short timeout.

The overdrive runs repeat the reset and slot cases, so that the alternate timing set is checked on the same paths.

// File: rtl/owire_pkg.sv
package owire_pkg;

   typedef enum logic [1:0] {
      OW_BIT1  = 2'b00,
      OW_BIT0  = 2'b01,
      OW_RESET = 2'b10
   } ow_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SLOT,
      ST_RLOW,
      ST_SETTLE,
      ST_ALARM,
      ST_PRES
   } ow_state_e;

endpackage

// File: rtl/owire_sync.sv
module owire_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("owire_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/owire_us_counter.sv
module owire_us_counter #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         tick,
   output logic [W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    count <= '0;
      else if (clear)                count <= '0;
      else if (tick && count != '1)  count <= count + 1'b1;
   end
endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine
   import owire_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int NRM_RST_LOW    = 480,
   parameter int NRM_RST_REC    = 480,
   parameter int NRM_SAMPLE     = 15,
   parameter int NRM_SLOT       = 60,
   parameter int NRM_W0_LOW     = 60,
   parameter int NRM_W1_LOW     = 1,
   parameter int NRM_PRES_FIRST = 15,
   parameter int NRM_PRES_LAST  = 75,
   parameter int NRM_SHORT_WAIT = 3840,
   parameter int OD_RST_LOW     = 70,
   parameter int OD_RST_REC     = 70,
   parameter int OD_SAMPLE      = 2,
   parameter int OD_SLOT        = 8,
   parameter int OD_W0_LOW      = 8,
   parameter int OD_W1_LOW      = 1,
   parameter int OD_PRES_FIRST  = 2,
   parameter int OD_PRES_LAST   = 10,
   parameter int OD_SHORT_WAIT  = 480
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_us,
   input  logic       start,
   input  logic [1:0] slot_kind,
   input  logic       overdrive,
   input  logic       line_in,
   output logic       drive_low,
   output logic       done,
   output logic       result,
   output logic       short_flag
);
   localparam int SPAN = NRM_RST_LOW + NRM_SHORT_WAIT + NRM_RST_REC
                       + OD_RST_LOW + OD_SHORT_WAIT + OD_RST_REC + NRM_SLOT + 8;
   localparam int CW   = $clog2(SPAN + 1);

   generate
      if (NRM_W1_LOW >= NRM_SAMPLE || NRM_SAMPLE >= NRM_SLOT || NRM_W0_LOW > NRM_SLOT)
         begin : g_bad_nrm_slot
            $error("owire_slot_engine: normal slot timing out of order");
         end
      if (OD_W1_LOW >= OD_SAMPLE || OD_SAMPLE >= OD_SLOT || OD_W0_LOW > OD_SLOT)
         begin : g_bad_od_slot
            $error("owire_slot_engine: overdrive slot timing out of order");
         end
      if (NRM_PRES_FIRST > NRM_PRES_LAST || NRM_PRES_LAST >= NRM_RST_REC ||
          OD_PRES_FIRST > OD_PRES_LAST || OD_PRES_LAST >= OD_RST_REC)
         begin : g_bad_pres
            $error("owire_slot_engine: presence window must end before recovery");
         end
   endgenerate

   // line synchronizer
   logic line_s;
   owire_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s));

   // phase counter
   logic          cnt_clr;
   logic [CW-1:0] cnt;
   owire_us_counter #(.W(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clear(cnt_clr), .tick(tick_us), .count(cnt));

   ow_state_e state;
   ow_kind_e  kind_q;
   logic      od_q, drive_q, done_q, result_q, short_q, pres_seen;

   // timing set for the operation in flight
   logic [CW-1:0] t_rst_low, t_rec, t_sample, t_slot, t_w0, t_w1, t_pf, t_pl, t_short;
   always_comb begin
      if (od_q) begin
         t_rst_low = CW'(OD_RST_LOW);   t_rec   = CW'(OD_RST_REC);
         t_sample  = CW'(OD_SAMPLE);    t_slot  = CW'(OD_SLOT);
         t_w0      = CW'(OD_W0_LOW);    t_w1    = CW'(OD_W1_LOW);
         t_pf      = CW'(OD_PRES_FIRST); t_pl   = CW'(OD_PRES_LAST);
         t_short   = CW'(OD_SHORT_WAIT);
      end else begin
         t_rst_low = CW'(NRM_RST_LOW);  t_rec   = CW'(NRM_RST_REC);
         t_sample  = CW'(NRM_SAMPLE);   t_slot  = CW'(NRM_SLOT);
         t_w0      = CW'(NRM_W0_LOW);   t_w1    = CW'(NRM_W1_LOW);
         t_pf      = CW'(NRM_PRES_FIRST); t_pl  = CW'(NRM_PRES_LAST);
         t_short   = CW'(NRM_SHORT_WAIT);
      end
   end

   logic [CW-1:0] low_len;
   assign low_len = (kind_q == OW_BIT0) ? t_w0 : t_w1;

   always_comb begin
      unique case (state)
         ST_IDLE:   cnt_clr = start;
         ST_RLOW:   cnt_clr = tick_us && (cnt == t_rst_low);
         ST_SETTLE: cnt_clr = tick_us && (cnt == CW'(1)) && !line_s;
         ST_ALARM:  cnt_clr = line_s;
         default:   cnt_clr = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind_q    <= OW_BIT1;
         od_q      <= 1'b0;
         drive_q   <= 1'b0;
         done_q    <= 1'b0;
         result_q  <= 1'b1;
         short_q   <= 1'b0;
         pres_seen <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               kind_q    <= ow_kind_e'(slot_kind);
               od_q      <= overdrive;
               drive_q   <= 1'b1;
               short_q   <= 1'b0;
               pres_seen <= 1'b0;
               state     <= (ow_kind_e'(slot_kind) == OW_RESET) ? ST_RLOW : ST_SLOT;
            end
            ST_SLOT: if (tick_us) begin
               if (cnt == low_len)  drive_q  <= 1'b0;
               if (cnt == t_sample) result_q <= line_s;
               if (cnt == t_slot) begin
                  drive_q <= 1'b0;
                  done_q  <= 1'b1;
                  state   <= ST_IDLE;
               end
            end
            ST_RLOW: if (tick_us && cnt == t_rst_low) begin
               drive_q <= 1'b0;
               state   <= ST_SETTLE;
            end
            ST_SETTLE: if (tick_us && cnt == CW'(1)) begin
               state <= line_s ? ST_PRES : ST_ALARM;
            end
            ST_ALARM: begin
               if (line_s) state <= ST_PRES;
               else if (tick_us && cnt == t_short) begin
                  short_q  <= 1'b1;
                  result_q <= 1'b1;
                  done_q   <= 1'b1;
                  state    <= ST_IDLE;
               end
            end
            ST_PRES: begin
               if (!line_s && cnt >= t_pf && cnt <= t_pl) pres_seen <= 1'b1;
               if (tick_us && cnt == t_rec) begin
                  result_q <= !pres_seen;
                  done_q   <= 1'b1;
                  state    <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign drive_low  = drive_q;
   assign done       = done_q;
   assign result     = result_q;
   assign short_flag = short_q;

   // ---------------- assertions ----------------
   // independent tick count since the accepted start
   logic [CW-1:0] chk_t;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            chk_t <= '0;
      else if (state == ST_IDLE && start)    chk_t <= '0;
      else if (tick_us && chk_t != '1)       chk_t <= chk_t + 1'b1;
   end

   // R2 R3 R10
   slot_min_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && kind_q != OW_RESET) |-> chk_t >= t_slot);

   // R5
   rst_low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(drive_low) && kind_q == OW_RESET) |-> chk_t >= t_rst_low);

   // R6
   rst_total_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && kind_q == OW_RESET && !short_flag) |-> chk_t >= (t_rst_low + t_rec));

   // R4
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4
   done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !drive_low);

   // R9
   short_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      short_flag |-> result);

   // R9
   short_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(short_flag) |-> chk_t >= (t_rst_low + t_short));
endmodule

// File: tb/sim_owire_slot_engine.sv
module sim_owire_slot_engine;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       start;
   logic [1:0] slot_kind;
   logic       overdrive;
   logic       line_in;
   logic       drive_low, done, result, short_flag;
   logic [1:0] tdiv;
   logic       tick_us;

   int vectors = 0;
   int miscompares = 0;

   always #2 clk = ~clk;

   always @(posedge clk or negedge rst_n)
      if (!rst_n) tdiv <= 2'd0;
      else        tdiv <= tdiv + 2'd1;
   assign tick_us = (tdiv == 2'd3);

   // device model: pulls the line in two windows of bench microseconds
   int  us;
   logic active;
   int  a1, b1, a2, b2;
   logic pull;

   always @(posedge clk or negedge rst_n)
      if (!rst_n) begin us <= 0; active <= 1'b0; end
      else if (start) begin us <= 0; active <= 1'b1; end
      else if (done) active <= 1'b0;
      else if (active && tick_us) us <= us + 1;

   always_comb pull = active && ((us >= a1 && us < b1) || (us >= a2 && us < b2));
   assign line_in = !(drive_low || pull);

   owire_slot_engine u0 (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .start(start),
      .slot_kind(slot_kind), .overdrive(overdrive), .line_in(line_in),
      .drive_low(drive_low), .done(done), .result(result), .short_flag(short_flag));

   task automatic chk(input string req, input int act, input int lo, input int hi);
      vectors++;
      if (act < lo || act > hi) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   int low_t, done_t, res_v, sh_v;

   task automatic run_op(input logic [1:0] k, input logic o,
                         input int p1, input int q1, input int p2, input int q2);
      int waited;
      a1 = p1; b1 = q1; a2 = p2; b2 = q2;
      low_t = 0; done_t = -1; waited = 0;
      @(negedge clk);
      slot_kind = k; overdrive = o; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && waited < 40000) begin
         if (tick_us && drive_low) low_t++;
         @(negedge clk);
         waited++;
      end
      done_t = us; res_v = result; sh_v = short_flag;
      @(negedge clk);
      chk("R4 done single cycle", done, 0, 0);
      chk("R4 line released after done", drive_low, 0, 0);
   endtask

   task automatic t_reset_state;
      chk("R1 drive_low after reset", drive_low, 0, 0);
      chk("R1 done after reset", done, 0, 0);
      chk("R1 short_flag after reset", short_flag, 0, 0);
      chk("R1 result after reset", result, 1, 1);
   endtask

   task automatic t_write0;
      run_op(2'b01, 1'b0, 0, 0, 0, 0);
      chk("R2 write-0 low time", low_t, 60, 62);
      chk("R2 write-0 done time", done_t, 60, 63);
      chk("R2 write-0 result", res_v, 0, 0);
      repeat (20) @(negedge clk);
      chk("R4 result held while idle", result, 0, 0);
   endtask

   task automatic t_read;
      run_op(2'b00, 1'b0, 0, 0, 0, 0);
      chk("R3 read low pulse", low_t, 1, 2);
      chk("R3 read done time", done_t, 60, 63);
      chk("R3 read no device", res_v, 1, 1);
      run_op(2'b00, 1'b0, 0, 30, 0, 0);
      chk("R3 device low across sample", res_v, 0, 0);
      run_op(2'b00, 1'b0, 20, 40, 0, 0);
      chk("R3 device low after sample", res_v, 1, 1);
   endtask

   task automatic t_reset_presence;
      run_op(2'b10, 1'b0, 511, 631, 0, 0);
      chk("R5 reset low time", low_t, 480, 482);
      chk("R6 reset done time", done_t, 960, 965);
      chk("R7 presence seen", res_v, 0, 0);
      chk("R8 no short on presence", sh_v, 0, 0);
      run_op(2'b10, 1'b0, 0, 0, 0, 0);
      chk("R7 no presence", res_v, 1, 1);
      chk("R6 reset done time no device", done_t, 960, 965);
   endtask

   task automatic t_reset_alarm;
      run_op(2'b10, 1'b0, 0, 1481, 1511, 1631);
      chk("R8 alarm done after rise", done_t, 1961, 1967);
      chk("R8 alarm presence result", res_v, 0, 0);
      chk("R8 alarm short flag", sh_v, 0, 0);
   endtask

   task automatic t_reset_short;
      run_op(2'b10, 1'b0, 0, 100000, 0, 0);
      chk("R9 short done time", done_t, 4320, 4330);
      chk("R9 short flag set", sh_v, 1, 1);
      chk("R9 short result", res_v, 1, 1);
      repeat (20) @(negedge clk);
      chk("R4 short flag held", short_flag, 1, 1);
   endtask

   task automatic t_overdrive;
      run_op(2'b00, 1'b1, 0, 5, 0, 0);
      chk("R10 od read low pulse", low_t, 1, 2);
      chk("R10 od slot done time", done_t, 8, 11);
      chk("R10 od read device low", res_v, 0, 0);
      chk("R4 short cleared by start", short_flag, 0, 0);
      run_op(2'b00, 1'b1, 0, 0, 0, 0);
      chk("R10 od read no device", res_v, 1, 1);
      run_op(2'b01, 1'b1, 0, 0, 0, 0);
      chk("R10 od write-0 low time", low_t, 8, 10);
      run_op(2'b10, 1'b1, 74, 91, 0, 0);
      chk("R10 od reset low time", low_t, 70, 72);
      chk("R10 od reset done time", done_t, 140, 145);
      chk("R10 od presence", res_v, 0, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; slot_kind = 2'b00; overdrive = 1'b0;
      a1 = 0; b1 = 0; a2 = 0; b2 = 0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset_state();
      t_write0();
      t_read();
      t_reset_presence();
      t_reset_alarm();
      t_reset_short();
      t_overdrive();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule